// File: doc/BRIEF.md
# Block-Oriented Memory Bank with Node-Owned Atomic Lock

This block is the slave side of one memory bank on a cache-block bus. Every command names a whole aligned 64-byte block. The bank accepts it only when it is idle and, if a lock is held, only when the command comes from the lock holder. An accepted command is acknowledged one cycle later. A read then returns the block as two 32-byte beats. The beat named by address bit 5 comes first and the other half follows it. A write takes two 32-byte beats, always lower half first.

Two extra command codes give an I/O node atomic update of data smaller than a block. A read-with-lock reads the block and marks the bank as held by the issuing node. A write-with-unlock from that node writes the block back and frees the bank. While the bank is held, every command from any other node goes unacknowledged, so the other node sees no data and retries later.

The bank stores 2^IDX_W blocks. The block index comes from address bits [6 +: IDX_W]. Address bits [4:0] and the block-address bits above the index are not decoded here, because bank selection is done outside this block.

Top module: `atomic_bank`

## Requirements
- R1: A command is accepted when `cmd_valid` is high at a clock edge, the bank is idle, and the lock permits it. `cmd_ack` is high for exactly the one cycle after that edge. A command that is not accepted is never acknowledged.
- R2: After an accepted read (op 2'b00) or read-with-lock (op 2'b10), `rd_valid` is high for two consecutive cycles. The first of these cycles is the `cmd_ack` cycle.
- R3: The first read beat carries the subblock chosen by `cmd_addr[5]`: 0 means bytes 0..31 of the block and 1 means bytes 32..63. The second beat carries the other subblock.
- R4: `cmd_addr[4:0]` and block-address bits above `cmd_addr[6+IDX_W-1]` do not change which data is read or written.
- R5: After an accepted write (op 2'b01) or write-with-unlock (op 2'b11), the bank stores `wr_data` on the first two cycles with `wr_valid` high, counting from the `cmd_ack` cycle. The first beat goes to the lower subblock and the second to the upper subblock, whatever the value of `cmd_addr[5]`.
- R6: `busy` is high from the `cmd_ack` cycle until the transfer finishes. A command presented while `busy` is high is not acknowledged and has no effect.
- R7: An accepted read-with-lock also places the bank in the locked state and records `cmd_node` as the owner.
- R8: While the bank is locked, commands of any op from a node other than the owner are rejected and change no data. Commands from the owner are accepted.
- R9: A write-with-unlock from the owner releases the lock once its second data beat has been taken. After that, other nodes are accepted again.
- R10: A write-with-unlock issued while the bank is unlocked behaves as a plain write and leaves the bank unlocked.
- R11: Reset leaves the bank idle and unlocked, with `cmd_ack`, `rd_valid` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_op | input | 2 | 00 read, 01 write, 10 read-with-lock, 11 write-with-unlock |
| cmd_addr | input | ADDR_W | Byte address of the block; bit 5 selects the first subblock |
| cmd_node | input | NODE_W | ID of the requesting node |
| cmd_ack | output | 1 | Acknowledge, one cycle after acceptance |
| busy | output | 1 | A transfer is in progress |
| wr_valid | input | 1 | Write data beat valid |
| wr_data | input | SUB_W | Write data beat, 32 bytes |
| rd_valid | output | 1 | Read data beat valid |
| rd_data | output | SUB_W | Read data beat, 32 bytes |

## Verification
The bench targets the two wrap orders and checks the first beat against bit 5. A design that ignored the bit, or swapped the order, would return the wrong half first. Writes are issued with bit 5 set to catch a design that placed the first write beat by the wrap bit. Lock tests send reads, writes and unlock writes from a foreign node while the bank is held. They then read back from the owner, which shows a leaky lock either as an unexpected acknowledge or as changed data. Further tests cover an unlock write on an idle bank, which must not leave the bank held, and a reset while the bank is held, which must free it.

// File: rtl/atomic_bank_pkg.sv
package atomic_bank_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_RDLOCK   = 2'b10,
    OP_WRUNLOCK = 2'b11
  } bank_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_FIRST,
    ST_RD_SECOND,
    ST_WR_LOW,
    ST_WR_HIGH
  } bank_st_e;

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int SUB_W = 256,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W:0]   addr,
  input  logic [SUB_W-1:0] wdata,
  output logic [SUB_W-1:0] rdata
);

  localparam int DEPTH = 1 << (IDX_W + 1);

  logic [SUB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/bank_lock_ctl.sv
module bank_lock_ctl #(
  parameter int NODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] req_node,
  input  logic              grab,
  input  logic              release_i,
  output logic              node_ok
);

  logic              locked_q, locked_d;
  logic [NODE_W-1:0] owner_q, owner_d;
  logic              owner_en;

  always_comb begin
    locked_d = locked_q;
    owner_d  = owner_q;
    owner_en = 1'b0;
    if (release_i) begin
      locked_d = 1'b0;
    end
    if (grab) begin
      locked_d = 1'b1;
      owner_d  = req_node;
      owner_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else begin
      locked_q <= locked_d;
      if (owner_en) begin
        owner_q <= owner_d;
      end
    end
  end

  assign node_ok = !locked_q || (req_node == owner_q);

  // R8: a held bank is never re-grabbed by a foreign node
  assert_foreign_grab_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && grab) |-> (req_node == owner_q))
    else $error("lock taken over by a foreign node");

  // R9: the lock only falls after an unlock beat
  assert_release_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(release_i))
    else $error("lock dropped without an unlock write");

  // R7: the owner does not change while the lock is held
  assert_owner_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && $past(locked_q)) |-> $stable(owner_q))
    else $error("owner changed under lock");

endmodule

// File: rtl/bank_seq.sv
module bank_seq
  import atomic_bank_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic             cmd_wrap,
  input  logic             node_ok,
  input  logic             wr_valid,
  output logic             grab,
  output logic             release_o,
  output logic             cmd_ack,
  output logic             busy,
  output logic             rd_valid,
  output logic             mem_we,
  output logic [IDX_W:0]   mem_addr
);

  bank_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic             wrap_q, unl_q, ack_q;
  logic             accept;
  bank_op_e         op;

  assign op     = bank_op_e'(cmd_op);
  assign accept = cmd_valid && (st_q == ST_IDLE) && node_ok;
  assign grab   = accept && (op == OP_RDLOCK);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d = (op == OP_READ || op == OP_RDLOCK) ? ST_RD_FIRST : ST_WR_LOW;
        end
      end
      ST_RD_FIRST:  st_d = ST_RD_SECOND;
      ST_RD_SECOND: st_d = ST_IDLE;
      ST_WR_LOW:    if (wr_valid) st_d = ST_WR_HIGH;
      ST_WR_HIGH:   if (wr_valid) st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ack_q  <= 1'b0;
      idx_q  <= '0;
      wrap_q <= 1'b0;
      unl_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= accept;
      if (accept) begin
        idx_q  <= cmd_idx;
        wrap_q <= cmd_wrap;
        unl_q  <= (op == OP_WRUNLOCK);
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RD_FIRST:  mem_addr = {idx_q, wrap_q};
      ST_RD_SECOND: mem_addr = {idx_q, ~wrap_q};
      ST_WR_HIGH:   mem_addr = {idx_q, 1'b1};
      default:      mem_addr = {idx_q, 1'b0};
    endcase
  end

  assign cmd_ack   = ack_q;
  assign busy      = (st_q != ST_IDLE);
  assign rd_valid  = (st_q == ST_RD_FIRST) || (st_q == ST_RD_SECOND);
  assign mem_we    = wr_valid && ((st_q == ST_WR_LOW) || (st_q == ST_WR_HIGH));
  assign release_o = unl_q && (st_q == ST_WR_HIGH) && wr_valid;

  // R1: acknowledge is a single-cycle pulse
  assert_ack_single_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack)
    else $error("acknowledge held for more than one cycle");

  // R1: acknowledge coincides with the opening phase of a transfer
  assert_ack_opens_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> (st_q == ST_RD_FIRST || st_q == ST_WR_LOW))
    else $error("acknowledge without a transfer starting");

  // R3: the two read beats address opposite subblocks of one block
  assert_wrap_pair_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD_FIRST) |=> (rd_valid && mem_addr[0] != $past(mem_addr[0])
                               && mem_addr[IDX_W:1] == $past(mem_addr[IDX_W:1])))
    else $error("read beats not a wrapped pair");

  // R6: no acknowledge can follow a busy cycle directly
  assert_busy_no_ack_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_ack) |=> !cmd_ack)
    else $error("command accepted while busy");

  // R5: memory is written only during a write transfer
  assert_we_in_write_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !rd_valid))
    else $error("array written outside a write transfer");

endmodule

// File: rtl/atomic_bank.sv
module atomic_bank
  import atomic_bank_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NODE_W = 4,
  parameter int IDX_W  = 4,
  parameter int SUB_W  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [NODE_W-1:0] cmd_node,
  output logic              cmd_ack,
  output logic              busy,
  input  logic              wr_valid,
  input  logic [SUB_W-1:0]  wr_data,
  output logic              rd_valid,
  output logic [SUB_W-1:0]  rd_data
);

  localparam int IDX_LSB = 6;
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic           rst_n_sync;
  logic           node_ok, grab, release_w, mem_we;
  logic [IDX_W:0] mem_addr;
  logic           unused_addr_bits;

  assign unused_addr_bits = ^{cmd_addr[ADDR_W-1:IDX_MSB+1], cmd_addr[4:0]};

  bank_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bank_lock_ctl #(.NODE_W(NODE_W)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .req_node  (cmd_node),
    .grab      (grab),
    .release_i (release_w),
    .node_ok   (node_ok)
  );

  bank_seq #(.IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_addr[IDX_MSB:IDX_LSB]),
    .cmd_wrap  (cmd_addr[5]),
    .node_ok   (node_ok),
    .wr_valid  (wr_valid),
    .grab      (grab),
    .release_o (release_w),
    .cmd_ack   (cmd_ack),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
  );

  bank_store #(.SUB_W(SUB_W), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (wr_data),
    .rdata (rd_data)
  );

endmodule

// File: tb/atomic_bank_bench.sv
module atomic_bank_bench;

  localparam int ADDR_W = 40;
  localparam int NODE_W = 4;
  localparam int IDX_W  = 4;
  localparam int SUB_W  = 256;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_op = 2'b00;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [NODE_W-1:0] cmd_node = '0;
  logic              wr_valid = 1'b0;
  logic [SUB_W-1:0]  wr_data = '0;
  logic              cmd_ack, busy, rd_valid;
  logic [SUB_W-1:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [SUB_W-1:0] b0, b1;

  always #2 clk = ~clk;

  atomic_bank #(.ADDR_W(ADDR_W), .NODE_W(NODE_W), .IDX_W(IDX_W), .SUB_W(SUB_W)) u_atomic_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_node(cmd_node), .cmd_ack(cmd_ack), .busy(busy),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [SUB_W-1:0] act,
                     input logic [SUB_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int               m_phase;   // 0 idle, 1/2 read beats, 3/4 write beats
  int               m_blk;
  bit               m_wrap, m_unl, m_locked, m_ack;
  int               m_owner;
  logic [SUB_W-1:0] m_mem [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_locked = 0; m_ack = 0; m_owner = 0;
    end else begin
      m_ack = 0;
      case (m_phase)
        0: if (cmd_valid && (!m_locked || int'(cmd_node) == m_owner)) begin
             m_ack  = 1;
             m_blk  = int'(cmd_addr[6 +: IDX_W]);
             m_wrap = cmd_addr[5];
             m_unl  = (cmd_op == 2'b11);
             if (cmd_op == 2'b10) begin m_locked = 1; m_owner = int'(cmd_node); end
             m_phase = cmd_op[0] ? 3 : 1;
           end
        1: m_phase = 2;
        2: m_phase = 0;
        3: if (wr_valid) begin m_mem[m_blk*2] = wr_data; m_phase = 4; end
        4: if (wr_valid) begin
             m_mem[m_blk*2+1] = wr_data; m_phase = 0;
             if (m_unl) m_locked = 0;
           end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_ack == m_ack, "R1 ack", SUB_W'(cmd_ack), SUB_W'(m_ack));
      chk(busy == (m_phase != 0), "R6 busy", SUB_W'(busy), SUB_W'(m_phase != 0));
      chk(rd_valid == (m_phase == 1 || m_phase == 2), "R2 rd_valid", SUB_W'(rd_valid),
          SUB_W'(m_phase == 1 || m_phase == 2));
      if (m_phase == 1 || m_phase == 2) begin
        int key;
        key = m_blk*2 + int'((m_phase == 1) ? m_wrap : !m_wrap);
        if (m_mem.exists(key))
          chk(rd_data === m_mem[key], "R3 rd_data", rd_data, m_mem[key]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- directed tasks ----------------
  function automatic logic [ADDR_W-1:0] blk_addr(input int blk, input bit wrap);
    return ADDR_W'(blk) << 6 | (ADDR_W'(wrap) << 5);
  endfunction

  task automatic do_read(input logic [1:0] op, input logic [ADDR_W-1:0] a, input int nd,
                         input bit exp_ack, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_node = NODE_W'(nd);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ack == exp_ack, tag, SUB_W'(cmd_ack), SUB_W'(exp_ack));
    b0 = rd_data;
    @(negedge clk);
    b1 = rd_data;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] op, input logic [ADDR_W-1:0] a, input int nd,
                          input logic [SUB_W-1:0] d0, input logic [SUB_W-1:0] d1,
                          input bit exp_ack, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_node = NODE_W'(nd);
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ack == exp_ack, tag, SUB_W'(cmd_ack), SUB_W'(exp_ack));
    wr_valid = 1; wr_data = d0;
    @(negedge clk);
    wr_data = d1;
    @(negedge clk);
    wr_valid = 0;
  endtask

  localparam logic [SUB_W-1:0] A0 = {8{32'hA0A0_0001}};
  localparam logic [SUB_W-1:0] A1 = {8{32'hA1A1_0002}};
  localparam logic [SUB_W-1:0] C0 = {8{32'hC0C0_0003}};
  localparam logic [SUB_W-1:0] C1 = {8{32'hC1C1_0004}};
  localparam logic [SUB_W-1:0] B0 = {8{32'hB0B0_0005}};
  localparam logic [SUB_W-1:0] B1 = {8{32'hB1B1_0006}};
  localparam logic [SUB_W-1:0] D0 = {8{32'hD0D0_0007}};
  localparam logic [SUB_W-1:0] D1 = {8{32'hD1D1_0008}};
  localparam logic [SUB_W-1:0] E0 = {8{32'hE0E0_0009}};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(cmd_ack == 0 && rd_valid == 0 && busy == 0, "R11 reset outputs",
        SUB_W'({cmd_ack, rd_valid, busy}), '0);

    // R5 plain write, then R3 both wrap orders
    do_write(2'b01, blk_addr(5, 0), 1, A0, A1, 1, "R5 write ack");
    do_read(2'b00, blk_addr(5, 0), 2, 1, "R1 read ack");
    chk(b0 == A0 && b1 == A1, "R3 wrap0 order", b0, A0);
    do_read(2'b00, blk_addr(5, 1), 2, 1, "R1 read ack");
    chk(b0 == A1 && b1 == A0, "R3 wrap1 order", b0, A1);
    // R4 ignored address bits
    do_read(2'b00, blk_addr(5, 1) | 40'h1F | (40'h3 << 24), 3, 1, "R4 read ack");
    chk(b0 == A1 && b1 == A0, "R4 ignored bits", b0, A1);
    // R5 write order independent of bit 5
    do_write(2'b01, blk_addr(6, 1), 1, C0, C1, 1, "R5 write ack");
    do_read(2'b00, blk_addr(6, 0), 1, 1, "R5 read ack");
    chk(b0 == C0 && b1 == C1, "R5 lower beat first", b0, C0);

    // R6 command during busy
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'b00; cmd_addr = blk_addr(5, 0); cmd_node = 2;
    @(negedge clk);
    cmd_node = 3;          // first command acked here, second presented while busy
    @(negedge clk);
    cmd_valid = 0;
    chk(cmd_ack == 0, "R6 no ack when busy", SUB_W'(cmd_ack), '0);
    repeat (3) @(negedge clk);

    // R7/R8/R9/R10 lock sequence
    do_read(2'b10, blk_addr(5, 0), 1, 1, "R7 lock read ack");
    chk(b0 == A0, "R7 lock read data", b0, A0);
    do_read(2'b00, blk_addr(5, 0), 2, 0, "R8 foreign read rejected");
    do_write(2'b01, blk_addr(6, 0), 2, E0, E0, 0, "R8 foreign write rejected");
    do_read(2'b00, blk_addr(6, 0), 1, 1, "R8 owner read ack");
    chk(b0 == C0 && b1 == C1, "R8 data untouched", b0, C0);
    do_write(2'b11, blk_addr(5, 0), 2, E0, E0, 0, "R10 foreign unlock rejected");
    do_read(2'b00, blk_addr(5, 0), 3, 0, "R8 still locked");
    do_write(2'b11, blk_addr(5, 0), 1, B0, B1, 1, "R9 owner unlock ack");
    do_read(2'b00, blk_addr(5, 0), 2, 1, "R9 other node after unlock");
    chk(b0 == B0 && b1 == B1, "R9 unlock data", b0, B0);
    do_write(2'b11, blk_addr(7, 0), 3, D0, D1, 1, "R10 unlock on idle bank");
    do_read(2'b00, blk_addr(7, 0), 2, 1, "R10 bank stays unlocked");
    chk(b0 == D0, "R10 unlock write data", b0, D0);

    // R11 reset frees a held lock
    do_read(2'b10, blk_addr(5, 0), 1, 1, "R7 lock read ack");
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    do_read(2'b00, blk_addr(5, 0), 2, 1, "R11 unlocked after reset");

    // random traffic checked by the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cmd_valid = ($urandom % 3) == 0;
      cmd_op    = 2'($urandom);
      cmd_addr  = {8'($urandom), 32'($urandom)};
      cmd_node  = NODE_W'($urandom % 3);
      wr_valid  = ($urandom % 2) == 1;
      wr_data   = {8{32'($urandom)}};
    end
    @(negedge clk);
    cmd_valid = 0; wr_valid = 0;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule